// File: doc/BRIEF.md
# Program Counter Stack with Interrupt Entry

This block produces the fetch address for a small 4-bit microcontroller core. It keeps three 12-bit program counter registers arranged as a hardware stack. A level pointer selects the register that is currently driving the ROM address. The instruction decoder drives one-cycle strobes for jump, call, return and return-from-interrupt, together with a target address. A separate step strobe marks the cycle in which an instruction completes. When the step strobe is high and no branch strobe is set, the active counter advances by one.

Several peripheral request lines are merged with an OR into one request. The request is taken only at an instruction boundary, while interrupts are enabled, while no handler is already running and while a free level is left. Taking it works like a forced call to address 1 and sets an in-handler flag. The interrupted counter keeps the address of the next instruction. Return-from-interrupt restores that level and clears the flag. A call made from the topmost level does not change the stack and sets a sticky overflow flag instead.

Top module: `pcstack_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the ROM address is 0, the active level is the bottom one, and the in-handler flag and the overflow flag are 0.
- R2: A step with no strobe raises the ROM address by one, wrapping from 0xFFF to 0x000. In a cycle with step low, the address, the level and the flags do not change, whatever the strobes are.
- R3: A step with the jump strobe (and no call, return or return-from-interrupt) loads the target into the active level.
- R4: A step with the call strobe below the top level stores the current address plus one in the current level, moves up one level and loads the target there.
- R5: A step with the return strobe moves down one level, and the address becomes the value saved in that level. At the bottom level, a return acts as a plain step.
- R6: A step with the call strobe at the top (third) level sets the overflow flag. The flag stays set until reset. The address advances by one, and the level and the saved values are left unchanged.
- R7: An interrupt is taken on a step when any request line is high, enable is 1, the in-handler flag is 0 and the level is below the top. The address becomes 0x001 and the in-handler flag becomes 1. The interrupted level keeps its address plus one, or the jump target when jump was strobed in that step.
- R8: No interrupt is taken while enable is 0, while the in-handler flag is 1 (so handlers never nest), or while the top level is active. A plain step is done instead.
- R9: A step with the return-from-interrupt strobe moves down one level and clears the in-handler flag. At the bottom level it clears the flag and acts as a plain step.
- R10: When several strobes come in the same step, call wins over return-from-interrupt, that wins over return, and return wins over jump.
- R11: No interrupt is taken on a step that carries call, return or return-from-interrupt. A pending request is taken at a later step without those strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction completes this cycle |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| target_i | input | 12 | Jump or call destination |
| irq_i | input | 4 | Peripheral interrupt request lines |
| int_en_i | input | 1 | Interrupt enable |
| rom_addr_o | output | 12 | Current fetch address |
| int_flag_o | output | 1 | In-handler flag |
| ovf_o | output | 1 | Sticky stack overflow flag |

## Verification
The main function is tried with a walk through all three levels using nested calls and returns. Each return must land on its own saved address, which exposes any swap between levels. Interrupt requests are applied on different lines and in different states: enabled, disabled, while a handler runs, at the top level, and together with a jump, a call or a return. This separates a correct acceptance condition from one that ignores the level, the flag or the branch strobes. Steps with several strobes set confirm the priority order. A call at the top level confirms that the overflow flag sets and stays set while the saved addresses survive.

// File: rtl/pcstack_pkg.sv
package pcstack_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_SEQ,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET,
    ACT_RETI,
    ACT_IRQ,
    ACT_OVF
  } pcs_act_e;
endpackage

// File: rtl/pcs_irq_merge.sv
module pcs_irq_merge #(
  parameter int IRQ_N = 4
) (
  input  logic [IRQ_N-1:0] irq_i,
  input  logic             step_i,
  input  logic             int_en_i,
  input  logic             int_flag_i,
  input  logic             level_full_i,
  input  logic             flow_busy_i,
  output logic             accept_o
);
  logic any_req;

  always_comb begin
    any_req  = |irq_i;
    accept_o = any_req & step_i & int_en_i & ~int_flag_i
             & ~level_full_i & ~flow_busy_i;
  end
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcstack_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic            jump_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            accept_i,
  output logic [SP_W-1:0] sp_o,
  output logic            level_full_o,
  output logic            int_flag_o,
  output logic            ovf_o,
  output logic            wr_cur_o,
  output logic            cur_tgt_o,
  output logic            wr_nxt_o,
  output logic            nxt_vec_o
);
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  pcs_act_e        act;
  logic [SP_W-1:0] sp_q, sp_d;
  logic            int_q, int_d;
  logic            ovf_q, ovf_d;
  logic            at_bottom;

  // Pick the action for this cycle: call, then reti, then ret, then irq, then jump
  always_comb begin
    at_bottom = (sp_q == '0);
    act       = ACT_HOLD;
    if (step_i) begin
      if (call_i)        act = (sp_q == LAST) ? ACT_OVF : ACT_CALL;
      else if (reti_i)   act = ACT_RETI;
      else if (ret_i)    act = ACT_RET;
      else if (accept_i) act = ACT_IRQ;
      else if (jump_i)   act = ACT_JUMP;
      else               act = ACT_SEQ;
    end
  end

  // Next state and write controls for the stack entries
  always_comb begin
    sp_d      = sp_q;
    int_d     = int_q;
    ovf_d     = ovf_q;
    wr_cur_o  = 1'b0;
    cur_tgt_o = 1'b0;
    wr_nxt_o  = 1'b0;
    nxt_vec_o = 1'b0;
    unique case (act)
      ACT_SEQ:  wr_cur_o = 1'b1;
      ACT_JUMP: begin
        wr_cur_o  = 1'b1;
        cur_tgt_o = 1'b1;
      end
      ACT_CALL: begin
        wr_cur_o = 1'b1;
        wr_nxt_o = 1'b1;
        sp_d     = sp_q + SP_W'(1);
      end
      ACT_OVF: begin
        wr_cur_o = 1'b1;
        ovf_d    = 1'b1;
      end
      ACT_RET: begin
        if (at_bottom) wr_cur_o = 1'b1;
        else           sp_d     = sp_q - SP_W'(1);
      end
      ACT_RETI: begin
        int_d = 1'b0;
        if (at_bottom) wr_cur_o = 1'b1;
        else           sp_d     = sp_q - SP_W'(1);
      end
      ACT_IRQ: begin
        wr_cur_o  = 1'b1;
        cur_tgt_o = jump_i;
        wr_nxt_o  = 1'b1;
        nxt_vec_o = 1'b1;
        int_d     = 1'b1;
        sp_d      = sp_q + SP_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      int_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (step_i) begin
      sp_q  <= sp_d;
      int_q <= int_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    sp_o         = sp_q;
    level_full_o = (sp_q == LAST);
    int_flag_o   = int_q;
    ovf_o        = ovf_q;
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int              PC_W   = 12,
  parameter int              DEPTH  = 3,
  parameter logic [PC_W-1:0] VECTOR = 12'h001,
  localparam int             SP_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SP_W-1:0] sp_i,
  input  logic            wr_cur_i,
  input  logic            cur_tgt_i,
  input  logic            wr_nxt_i,
  input  logic            nxt_vec_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] cur_pc_o
);
  logic [PC_W-1:0] pc_all [DEPTH];
  logic [PC_W-1:0] cur_pc;
  logic [PC_W-1:0] cur_inc;
  logic [PC_W-1:0] nxt_val;
  logic [PC_W-1:0] cur_val;

  always_comb begin
    cur_pc = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sp_i == SP_W'(k)) cur_pc = pc_all[k];
    end
    cur_inc = cur_pc + PC_W'(1);
    cur_val = cur_tgt_i ? target_i : cur_inc;
    nxt_val = nxt_vec_i ? VECTOR : target_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic            sel_cur, sel_nxt, en;
    logic [PC_W-1:0] d, q;

    always_comb begin
      sel_cur = ({1'b0, sp_i} == (SP_W+1)'(g));
      sel_nxt = ({1'b0, sp_i} + (SP_W+1)'(1) == (SP_W+1)'(g));
      en      = (wr_cur_i & sel_cur) | (wr_nxt_i & sel_nxt);
      d       = (wr_nxt_i & sel_nxt) ? nxt_val : cur_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign pc_all[g] = q;
  end

  assign cur_pc_o = cur_pc;
endmodule

// File: rtl/pcstack_unit.sv
module pcstack_unit #(
  parameter int              PC_W   = 12,
  parameter int              DEPTH  = 3,
  parameter int              IRQ_N  = 4,
  parameter logic [PC_W-1:0] VECTOR = 12'h001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             jump_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [IRQ_N-1:0] irq_i,
  input  logic             int_en_i,
  output logic [PC_W-1:0]  rom_addr_o,
  output logic             int_flag_o,
  output logic             ovf_o
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  logic [SP_W-1:0] sp;
  logic            level_full, int_flag, accept, flow_busy;
  logic            wr_cur, cur_tgt, wr_nxt, nxt_vec;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign flow_busy = call_i | ret_i | reti_i;

  pcs_irq_merge #(.IRQ_N(IRQ_N)) u_irq (
    .irq_i        (irq_i),
    .step_i       (step_i),
    .int_en_i     (int_en_i),
    .int_flag_i   (int_flag),
    .level_full_i (level_full),
    .flow_busy_i  (flow_busy),
    .accept_o     (accept)
  );

  pcs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .step_i       (step_i),
    .jump_i       (jump_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .reti_i       (reti_i),
    .accept_i     (accept),
    .sp_o         (sp),
    .level_full_o (level_full),
    .int_flag_o   (int_flag),
    .ovf_o        (ovf_o),
    .wr_cur_o     (wr_cur),
    .cur_tgt_o    (cur_tgt),
    .wr_nxt_o     (wr_nxt),
    .nxt_vec_o    (nxt_vec)
  );

  pcs_stack #(.PC_W(PC_W), .DEPTH(DEPTH), .VECTOR(VECTOR)) u_stack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sp_i      (sp),
    .wr_cur_i  (wr_cur),
    .cur_tgt_i (cur_tgt),
    .wr_nxt_i  (wr_nxt),
    .nxt_vec_i (nxt_vec),
    .target_i  (target_i),
    .cur_pc_o  (rom_addr_o)
  );

  assign int_flag_o = int_flag;
endmodule

// File: rtl/pcstack_unit_chk.sv
module pcstack_unit_chk #(
  parameter int              PC_W   = 12,
  parameter int              DEPTH  = 3,
  parameter logic [PC_W-1:0] VECTOR = 12'h001,
  localparam int             SP_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_i,
  input logic            jump_i,
  input logic            call_i,
  input logic            ret_i,
  input logic            reti_i,
  input logic            int_en_i,
  input logic [PC_W-1:0] target_i,
  input logic [PC_W-1:0] rom_addr_o,
  input logic            int_flag_o,
  input logic            ovf_o,
  input logic [SP_W-1:0] sp_i
);
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  p_hold_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(rom_addr_o) && $stable(int_flag_o) && $stable(sp_i));

  p_jump_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && jump_i && !call_i && !ret_i && !reti_i && (int_flag_o || !int_en_i)
    |=> rom_addr_o == $past(target_i));

  p_call_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && call_i && sp_i != LAST
    |=> rom_addr_o == $past(target_i) && sp_i == $past(sp_i) + SP_W'(1));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_i <= LAST);

  p_entry_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag_o) |-> rom_addr_o == VECTOR);

  p_no_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_flag_o && !(step_i && reti_i && !call_i) |=> int_flag_o);

  p_reti_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && reti_i && !call_i |=> !int_flag_o);
endmodule

bind pcstack_unit pcstack_unit_chk #(.PC_W(PC_W), .DEPTH(DEPTH), .VECTOR(VECTOR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .step_i     (step_i),
  .jump_i     (jump_i),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .reti_i     (reti_i),
  .int_en_i   (int_en_i),
  .target_i   (target_i),
  .rom_addr_o (rom_addr_o),
  .int_flag_o (int_flag_o),
  .ovf_o      (ovf_o),
  .sp_i       (sp)
);

// File: tb/tb_pcstack_unit.sv
module tb_pcstack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, jump_i, call_i, ret_i, reti_i, int_en_i;
  logic [11:0] target_i;
  logic [3:0]  irq_i;
  logic [11:0] rom_addr_o;
  logic        int_flag_o, ovf_o;
  int          n_tests = 0;
  int          n_fail  = 0;
  int          cyc     = 0;
  bit          done    = 1'b0;

  always #4 clk = ~clk;

  pcstack_unit dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i), .call_i(call_i),
    .ret_i(ret_i), .reti_i(reti_i), .target_i(target_i), .irq_i(irq_i),
    .int_en_i(int_en_i), .rom_addr_o(rom_addr_o), .int_flag_o(int_flag_o), .ovf_o(ovf_o)
  );

  // Fields: req id[4] {call,ret,reti,jump}[4] target[12] irq[4] en[1] exp_addr[12] exp_int[1] exp_ovf[1]
  localparam int NV = 25;
  localparam logic [38:0] VEC [NV] = '{
    {4'd2,  4'b0000, 12'h000, 4'h0, 1'b0, 12'h001, 1'b0, 1'b0}, // R2 step
    {4'd3,  4'b0001, 12'h100, 4'h0, 1'b0, 12'h100, 1'b0, 1'b0}, // R3 jump
    {4'd2,  4'b0000, 12'h000, 4'h0, 1'b0, 12'h101, 1'b0, 1'b0},
    {4'd4,  4'b1000, 12'h200, 4'h0, 1'b0, 12'h200, 1'b0, 1'b0}, // R4 call to level 1
    {4'd2,  4'b0000, 12'h000, 4'h0, 1'b0, 12'h201, 1'b0, 1'b0},
    {4'd4,  4'b1000, 12'h300, 4'h0, 1'b0, 12'h300, 1'b0, 1'b0}, // R4 call to level 2
    {4'd8,  4'b0000, 12'h000, 4'h1, 1'b1, 12'h301, 1'b0, 1'b0}, // R8 top level blocks irq
    {4'd5,  4'b0100, 12'h000, 4'h0, 1'b0, 12'h202, 1'b0, 1'b0}, // R5 return
    {4'd5,  4'b0100, 12'h000, 4'h0, 1'b0, 12'h102, 1'b0, 1'b0}, // R5 return
    {4'd8,  4'b0000, 12'h000, 4'h4, 1'b0, 12'h103, 1'b0, 1'b0}, // R8 disabled
    {4'd7,  4'b0000, 12'h000, 4'h4, 1'b1, 12'h001, 1'b1, 1'b0}, // R7 accept
    {4'd8,  4'b0000, 12'h000, 4'h8, 1'b1, 12'h002, 1'b1, 1'b0}, // R8 no nesting
    {4'd4,  4'b1000, 12'h050, 4'h0, 1'b0, 12'h050, 1'b1, 1'b0}, // R4 call in handler
    {4'd5,  4'b0100, 12'h000, 4'h0, 1'b0, 12'h003, 1'b1, 1'b0}, // R5
    {4'd9,  4'b0010, 12'h000, 4'h0, 1'b0, 12'h104, 1'b0, 1'b0}, // R9 resume
    {4'd7,  4'b0001, 12'h7FF, 4'h2, 1'b1, 12'h001, 1'b1, 1'b0}, // R7 irq with jump
    {4'd9,  4'b0010, 12'h000, 4'h0, 1'b0, 12'h7FF, 1'b0, 1'b0}, // R9 resume at jump target
    {4'd11, 4'b1000, 12'hABC, 4'h1, 1'b1, 12'hABC, 1'b0, 1'b0}, // R11 call blocks irq
    {4'd11, 4'b0100, 12'h000, 4'h1, 1'b1, 12'h800, 1'b0, 1'b0}, // R11 ret blocks irq
    {4'd2,  4'b0000, 12'h000, 4'h0, 1'b0, 12'h801, 1'b0, 1'b0},
    {4'd3,  4'b0001, 12'hFFF, 4'h0, 1'b0, 12'hFFF, 1'b0, 1'b0},
    {4'd2,  4'b0000, 12'h000, 4'h0, 1'b0, 12'h000, 1'b0, 1'b0}, // R2 wrap
    {4'd10, 4'b1001, 12'h444, 4'h0, 1'b0, 12'h444, 1'b0, 1'b0}, // R10 call over jump
    {4'd10, 4'b0101, 12'h555, 4'h0, 1'b0, 12'h001, 1'b0, 1'b0}, // R10 ret over jump
    {4'd9,  4'b0110, 12'h000, 4'h0, 1'b0, 12'h002, 1'b0, 1'b0}  // R9 reti at bottom
  };

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [3:0] fl, input logic [11:0] tg,
                       input logic [3:0] iq, input logic en);
    step_i   = st;
    {call_i, ret_i, reti_i, jump_i} = fl;
    target_i = tg;
    irq_i    = iq;
    int_en_i = en;
    @(negedge clk);
    step_i = 1'b0;
    {call_i, ret_i, reti_i, jump_i} = 4'b0000;
    irq_i  = 4'h0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 addr in reset", rom_addr_o, 12'h000);
    chk("R1 int in reset", {11'd0, int_flag_o}, 12'h000);
    chk("R1 ovf in reset", {11'd0, ovf_o}, 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 addr after release", rom_addr_o, 12'h000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step_i = 0; jump_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    int_en_i = 0; target_i = '0; irq_i = '0;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      drive(1'b1, v[34:31], v[30:19], v[18:15], v[14]);
      chk($sformatf("R%0d table[%0d] addr", v[38:35], i), rom_addr_o, v[13:2]);
      chk($sformatf("R%0d table[%0d] int", v[38:35], i), {11'd0, int_flag_o}, {11'd0, v[1]});
      chk($sformatf("R%0d table[%0d] ovf", v[38:35], i), {11'd0, ovf_o}, {11'd0, v[0]});
    end

    // R2: no step, strobes ignored
    drive(1'b0, 4'b0001, 12'h3AA, 4'hF, 1'b1);
    chk("R2 hold addr", rom_addr_o, 12'h002);
    chk("R2 hold int", {11'd0, int_flag_o}, 12'h000);

    // R6: overflow at top level
    drive(1'b1, 4'b1000, 12'h010, 4'h0, 1'b0);
    drive(1'b1, 4'b1000, 12'h020, 4'h0, 1'b0);
    chk("R4 second call", rom_addr_o, 12'h020);
    drive(1'b1, 4'b1000, 12'h030, 4'h0, 1'b0);
    chk("R6 ovf set", {11'd0, ovf_o}, 12'h001);
    chk("R6 addr advances", rom_addr_o, 12'h021);
    drive(1'b1, 4'b0000, 12'h000, 4'h0, 1'b0);
    chk("R6 ovf sticky", {11'd0, ovf_o}, 12'h001);
    drive(1'b1, 4'b0100, 12'h000, 4'h0, 1'b0);
    chk("R6 level 1 kept", rom_addr_o, 12'h011);
    drive(1'b1, 4'b0100, 12'h000, 4'h0, 1'b0);
    chk("R6 level 0 kept", rom_addr_o, 12'h003);
    chk("R6 ovf still set", {11'd0, ovf_o}, 12'h001);

    // R1: reset mid-run
    do_reset();

    // R5: return at bottom acts as a step
    drive(1'b1, 4'b0100, 12'h000, 4'h0, 1'b0);
    chk("R5 ret at bottom", rom_addr_o, 12'h001);

    // R7: request without step is not taken
    drive(1'b0, 4'b0000, 12'h000, 4'h2, 1'b1);
    chk("R7 no step no entry", {11'd0, int_flag_o}, 12'h000);
    drive(1'b1, 4'b0000, 12'h000, 4'h2, 1'b1);
    chk("R7 entry int", {11'd0, int_flag_o}, 12'h001);
    chk("R7 entry addr", rom_addr_o, 12'h001);
    drive(1'b1, 4'b0010, 12'h000, 4'h0, 1'b1);
    chk("R9 resume addr", rom_addr_o, 12'h002);
    chk("R9 int cleared", {11'd0, int_flag_o}, 12'h000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule